// File: doc/BRIEF.md
# Late-Write Synchronous SRAM Core

This block is a single-ported synchronous static memory with one shared data path. The data path is split into a data input, a data output and an output-enable flag. The interface samples a command on each rising clock edge. A command is a deselect, a read or a write.

A write supplies its address and lane enables in one cycle and its data one cycle later. The word then waits in a one-deep pending buffer. It reaches the storage array only when the next write arrives. Any read that hits the pending address merges the buffered lanes into the array word, so the caller always sees the most recent data.

Three read-output timings are available, picked by a two-bit mode input that is set before reset:
- **Flow-through**: data appears in the same cycle as the command.
- **Latched**: data appears from the falling edge of that cycle and is held for a full period.
- **Registered**: data appears in the following cycle.

An asynchronous output enable and an asynchronous sleep input can force the output idle at any time. Sleep also freezes all activity.

Top module: `lw_sram`

## Requirements
- R1: A rising edge with `sel_n` high (or `sleep` high) captures no operation. The output stays idle for that command, and memory and the pending buffer are untouched. With `sel_n` low, `wen_n` high is a read and `wen_n` low is a write.
- R2: Write data is sampled from `din` on the rising edge that follows the write command. It is held in a pending buffer and reaches the array only when the next write's data edge occurs. A later read of that address returns it either way.
- R3: The word has two 9-bit lanes. Lane 0 is bits 8:0 and is enabled by `ben_n[0]`. Lane 1 is bits 17:9 and is enabled by `ben_n[1]`. Enables are active low, and only enabled lanes of the addressed word change.
- R4: A write with every `ben_n` bit high is an abort. No lane changes, and the output stays idle for it. It still commits the previously pending write.
- R5: A read whose address equals the pending write address returns the buffered lanes that were enabled and the array contents for the other lanes.
- R6: With `rmode` = 01 (registered), a read captured at edge n drives `dout_en` high with its data from edge n+1 to edge n+2.
- R7: With `rmode` = 00 (flow-through), a read captured at edge n drives its data from edge n until edge n+1.
- R8: With `rmode` = 10 (latched), a read captured at edge n drives its data from the falling edge of that cycle until the next falling edge.
- R9: In latched and flow-through modes, the rising edge that captures a write turns the output idle at once, even if a latched read was still being shown.
- R10: `oe_n` high forces `dout_en` low without waiting for a clock.
- R11: `sleep` high forces `dout_en` low without waiting for a clock. A write whose data edge occurs during sleep is discarded, with array and buffer unchanged.
- R12: `rmode` = 11 behaves as registered mode. `rmode` must stay constant while out of reset.
- R13: After reset the output is idle and the pending buffer is empty. A write still pending when reset is asserted is dropped, while array contents are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through an internal synchronizer |
| sel_n | input | 1 | Chip select, active low |
| wen_n | input | 1 | Write enable, active low |
| ben_n | input | NBYTES | Per-lane write enables, active low |
| addr | input | $clog2(DEPTH) | Word address |
| din | input | NBYTES*BYTE_W | Write data, sampled one edge after the write command |
| dout | output | NBYTES*BYTE_W | Read data, zero while idle |
| dout_en | output | 1 | High when the data path would be driven (low means high impedance) |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Asynchronous sleep, active high |
| rmode | input | 2 | Read timing: 01 registered, 00 flow-through, 10 latched, 11 as registered |

## Verification
The bench builds the block with DEPTH = 16 and the default two 9-bit lanes, so random addresses collide often. A read frequently lands on the pending write, on a lane-masked word, or on a word just committed. Each timing mode, including code 11, is brought up after its own reset. Outputs are sampled both before and after the falling edge, which makes the latched mode's half-cycle hold and its cut-off on a write observable.

// File: rtl/lw_sram_pkg.sv
`timescale 1ns/1ps
package lw_sram_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'b00,
    OP_READ  = 2'b01,
    OP_WRITE = 2'b10
  } op_e;

  typedef enum logic [1:0] {
    RM_FLOW   = 2'b00,
    RM_REGREG = 2'b01,
    RM_LATCH  = 2'b10,
    RM_DUAL   = 2'b11
  } rmode_e;

endpackage

// File: rtl/lw_sram_cmd.sv
`timescale 1ns/1ps
module lw_sram_cmd
  import lw_sram_pkg::*;
#(
  parameter int AW = 10,
  parameter int NB = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sleep,
  input  logic          sel_n,
  input  logic          wen_n,
  input  logic [NB-1:0] ben_n,
  input  logic [AW-1:0] addr,
  output op_e           op_q,
  output logic [AW-1:0] addr_q,
  output logic [NB-1:0] ben_q
);

  op_e  op_d;
  logic cap_en;

  always_comb begin
    op_d = OP_IDLE;
    if (!sleep && !sel_n) begin
      op_d = wen_n ? OP_READ : OP_WRITE;
    end
    cap_en = (op_d != OP_IDLE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_IDLE;
      addr_q <= '0;
      ben_q  <= '1;
    end else begin
      op_q <= op_d;
      if (cap_en) begin
        addr_q <= addr;
        ben_q  <= ben_n;
      end
    end
  end

  // R1: a deselected edge never launches an operation
  a_r1_deselect_idle: assert property (@(posedge clk) disable iff (!rst_n)
    sel_n |=> (op_q == OP_IDLE));

  // R11: sleep blocks command capture
  a_r11_sleep_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> (op_q == OP_IDLE));

endmodule

// File: rtl/lw_sram_wbuf.sv
`timescale 1ns/1ps
module lw_sram_wbuf
  import lw_sram_pkg::*;
#(
  parameter int AW = 10,
  parameter int NB = 2,
  parameter int BW = 9,
  localparam int DW = NB * BW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sleep,
  input  op_e           op_q,
  input  logic [AW-1:0] addr_q,
  input  logic [NB-1:0] ben_q,
  input  logic [DW-1:0] din,
  input  logic [DW-1:0] arr_rdata,
  output logic [NB-1:0] commit_we,
  output logic [AW-1:0] commit_addr,
  output logic [DW-1:0] commit_data,
  output logic [DW-1:0] rd_word
);

  logic          buf_valid, buf_valid_d;
  logic [AW-1:0] buf_addr,  buf_addr_d;
  logic [DW-1:0] buf_data,  buf_data_d;
  logic [NB-1:0] buf_ben,   buf_ben_d;
  logic          take;
  logic          hit;

  // data edge of a write: retire the old entry and park the new one
  assign take = (op_q == OP_WRITE) && !sleep;
  assign hit  = buf_valid && (buf_addr == addr_q);

  always_comb begin
    buf_valid_d = buf_valid;
    buf_addr_d  = buf_addr;
    buf_data_d  = buf_data;
    buf_ben_d   = buf_ben;
    if (take) begin
      buf_valid_d = 1'b1;
      buf_addr_d  = addr_q;
      buf_data_d  = din;
      buf_ben_d   = ben_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_valid <= 1'b0;
      buf_addr  <= '0;
      buf_data  <= '0;
      buf_ben   <= '1;
    end else begin
      buf_valid <= buf_valid_d;
      buf_addr  <= buf_addr_d;
      buf_data  <= buf_data_d;
      buf_ben   <= buf_ben_d;
    end
  end

  assign commit_addr = buf_addr;
  assign commit_data = buf_data;

  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign commit_we[g] = take && buf_valid && !buf_ben[g];
    assign rd_word[g*BW +: BW] = (hit && !buf_ben[g]) ? buf_data[g*BW +: BW]
                                                     : arr_rdata[g*BW +: BW];
  end

  // R2: the data edge of a write parks address, lanes and data together
  a_r2_buffer_loads: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (buf_valid && buf_addr == $past(addr_q) &&
              buf_data == $past(din) && buf_ben == $past(ben_q)));

  // R11: no array write while asleep
  a_r11_no_commit_asleep: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> (commit_we == '0));

endmodule

// File: rtl/lw_sram_array.sv
`timescale 1ns/1ps
module lw_sram_array #(
  parameter int DEPTH = 1024,
  parameter int NB    = 2,
  parameter int BW    = 9,
  localparam int AW   = $clog2(DEPTH),
  localparam int DW   = NB * BW
) (
  input  logic          clk,
  input  logic [NB-1:0] we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  for (genvar g = 0; g < NB; g++) begin : g_lane
    logic [BW-1:0] mem_l [DEPTH];

    always_ff @(posedge clk) begin
      if (we[g]) begin
        mem_l[waddr] <= wdata[g*BW +: BW];
      end
    end

    assign rdata[g*BW +: BW] = mem_l[raddr];
  end

endmodule

// File: rtl/lw_sram_rdout.sv
`timescale 1ns/1ps
module lw_sram_rdout
  import lw_sram_pkg::*;
#(
  parameter int DW = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    rmode,
  input  op_e           op_q,
  input  logic [DW-1:0] rd_word,
  input  logic          oe_n,
  input  logic          sleep,
  output logic [DW-1:0] dout,
  output logic          dout_en
);

  logic          rd_live;
  logic          rr_en_q, lt_en_q;
  logic [DW-1:0] rr_data_q, lt_data_q;
  logic          en_m;
  logic [DW-1:0] data_m;

  assign rd_live = (op_q == OP_READ);

  // registered timing: one rising-edge stage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rr_en_q   <= 1'b0;
      rr_data_q <= '0;
    end else begin
      rr_en_q <= rd_live;
      if (rd_live) begin
        rr_data_q <= rd_word;
      end
    end
  end

  // latched timing: holding stage closes on the falling edge
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lt_en_q   <= 1'b0;
      lt_data_q <= '0;
    end else begin
      lt_en_q <= rd_live;
      if (rd_live) begin
        lt_data_q <= rd_word;
      end
    end
  end

  always_comb begin
    unique case (rmode_e'(rmode))
      RM_FLOW: begin
        en_m   = rd_live;
        data_m = rd_word;
      end
      RM_LATCH: begin
        en_m   = lt_en_q && (op_q != OP_WRITE);
        data_m = lt_data_q;
      end
      default: begin
        en_m   = rr_en_q;
        data_m = rr_data_q;
      end
    endcase
  end

  assign dout_en = en_m && !oe_n && !sleep;
  assign dout    = dout_en ? data_m : '0;

  // R6/R12: registered read shows up on the following edge
  a_r6_regreg_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    ((rmode == RM_REGREG || rmode == RM_DUAL) && rd_live) |=> (dout_en || oe_n || sleep));

  // R7: flow-through read drives the merged word in its own cycle
  a_r7_flow_same_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (rmode == RM_FLOW && rd_live && !oe_n && !sleep) |-> (dout_en && dout == rd_word));

  // R9: a captured write idles the output in latched and flow-through timing
  a_r9_write_tristates: assert property (@(posedge clk) disable iff (!rst_n)
    ((rmode == RM_FLOW || rmode == RM_LATCH) && op_q == OP_WRITE) |-> !dout_en);

endmodule

// File: rtl/lw_sram.sv
`timescale 1ns/1ps
module lw_sram
  import lw_sram_pkg::*;
#(
  parameter int DEPTH  = 1024,
  parameter int BYTE_W = 9,
  parameter int NBYTES = 2,
  localparam int AW    = $clog2(DEPTH),
  localparam int DW    = NBYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              wen_n,
  input  logic [NBYTES-1:0] ben_n,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     din,
  output logic [DW-1:0]     dout,
  output logic              dout_en,
  input  logic              oe_n,
  input  logic              sleep,
  input  logic [1:0]        rmode
);

  logic              rst_meta, rst_n_int;
  op_e               op_q;
  logic [AW-1:0]     addr_q;
  logic [NBYTES-1:0] ben_q;
  logic [NBYTES-1:0] commit_we;
  logic [AW-1:0]     commit_addr;
  logic [DW-1:0]     commit_data;
  logic [DW-1:0]     arr_rdata;
  logic [DW-1:0]     rd_word;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta  <= 1'b0;
      rst_n_int <= 1'b0;
    end else begin
      rst_meta  <= 1'b1;
      rst_n_int <= rst_meta;
    end
  end

  lw_sram_cmd #(.AW(AW), .NB(NBYTES)) u_cmd (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .sleep  (sleep),
    .sel_n  (sel_n),
    .wen_n  (wen_n),
    .ben_n  (ben_n),
    .addr   (addr),
    .op_q   (op_q),
    .addr_q (addr_q),
    .ben_q  (ben_q)
  );

  lw_sram_wbuf #(.AW(AW), .NB(NBYTES), .BW(BYTE_W)) u_wbuf (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .sleep       (sleep),
    .op_q        (op_q),
    .addr_q      (addr_q),
    .ben_q       (ben_q),
    .din         (din),
    .arr_rdata   (arr_rdata),
    .commit_we   (commit_we),
    .commit_addr (commit_addr),
    .commit_data (commit_data),
    .rd_word     (rd_word)
  );

  lw_sram_array #(.DEPTH(DEPTH), .NB(NBYTES), .BW(BYTE_W)) u_array (
    .clk   (clk),
    .we    (commit_we),
    .waddr (commit_addr),
    .wdata (commit_data),
    .raddr (addr_q),
    .rdata (arr_rdata)
  );

  lw_sram_rdout #(.DW(DW)) u_rdout (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .rmode   (rmode),
    .op_q    (op_q),
    .rd_word (rd_word),
    .oe_n    (oe_n),
    .sleep   (sleep),
    .dout    (dout),
    .dout_en (dout_en)
  );

  // R12: timing mode is strapped, not switched on the fly
  a_r12_mode_fixed: assert property (@(posedge clk) disable iff (!rst_n_int)
    $stable(rmode));

endmodule

// File: tb/lw_sram_tb.sv
`timescale 1ns/1ps
module lw_sram_tb;

  localparam int DEPTH = 16;
  localparam int BW    = 9;
  localparam int NB    = 2;
  localparam int AW    = $clog2(DEPTH);
  localparam int DW    = NB * BW;
  localparam int K_IDLE = 0, K_READ = 1, K_WRITE = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          sel_n, wen_n, oe_n, sleep;
  logic [NB-1:0] ben_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] din, dout;
  logic          dout_en;
  logic [1:0]    rmode;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  lw_sram #(.DEPTH(DEPTH), .BYTE_W(BW), .NBYTES(NB)) u_dut (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .wen_n(wen_n), .ben_n(ben_n),
    .addr(addr), .din(din), .dout(dout), .dout_en(dout_en),
    .oe_n(oe_n), .sleep(sleep), .rmode(rmode)
  );

  // reference model
  logic [DW-1:0] ref_mem [DEPTH];
  logic          rb_valid;
  logic [AW-1:0] rb_addr;
  logic [DW-1:0] rb_data;
  logic [NB-1:0] rb_ben;
  logic          pend_valid;
  logic [DW-1:0] pend_data;
  int            op_now, op_before;
  logic [DW-1:0] rd_now, rd_before;
  logic [1:0]    mode_now;

  function automatic logic [DW-1:0] rnd_word();
    logic [31:0] t;
    t = $urandom();
    return t[DW-1:0];
  endfunction

  function automatic logic [DW-1:0] model_read(input logic [AW-1:0] a);
    logic [DW-1:0] w;
    w = ref_mem[a];
    if (rb_valid && rb_addr == a) begin
      for (int i = 0; i < NB; i++) begin
        if (!rb_ben[i]) w[i*BW +: BW] = rb_data[i*BW +: BW];
      end
    end
    return w;
  endfunction

  task automatic chk(input string tag, input string what, input logic got_en,
                     input logic exp_en, input logic [DW-1:0] got_d,
                     input logic [DW-1:0] exp_d);
    checks++;
    if (got_en !== exp_en || (exp_en && got_d !== exp_d)) begin
      errors++;
      $display("FAIL %s %s at %0t: actual en=%0b data=%h expected en=%0b data=%h",
               tag, what, $time, got_en, got_d, exp_en, exp_d);
    end
  endtask

  // entered 1 ns after a rising edge, leaves 1 ns after the next one
  task automatic step(input logic s_n, input logic w_n, input logic [NB-1:0] b_n,
                      input logic [AW-1:0] a, input logic [DW-1:0] wd,
                      input logic oe, input logic slp, input string tag);
    logic gate, e_early, e_late;
    logic [DW-1:0] d_early, d_late;
    int cur;
    sel_n = s_n; wen_n = w_n; ben_n = b_n; addr = a; oe_n = oe; sleep = slp;
    din = pend_valid ? pend_data : rnd_word();
    gate = !oe && !slp;
    case (mode_now)
      2'b00: begin
        e_early = (op_now == K_READ); d_early = rd_now;
        e_late  = e_early;            d_late  = rd_now;
      end
      2'b10: begin
        e_early = (op_before == K_READ) && (op_now != K_WRITE); d_early = rd_before;
        e_late  = (op_now == K_READ);                           d_late  = rd_now;
      end
      default: begin
        e_early = (op_before == K_READ); d_early = rd_before;
        e_late  = e_early;               d_late  = rd_before;
      end
    endcase
    #1;
    chk(tag, "early", dout_en, e_early && gate, dout, d_early);
    #2;
    chk(tag, "late", dout_en, e_late && gate, dout, d_late);
    @(posedge clk);
    cur = slp ? K_IDLE : (s_n ? K_IDLE : (w_n ? K_READ : K_WRITE));
    if (op_now == K_WRITE && !slp) begin
      if (rb_valid) begin
        for (int i = 0; i < NB; i++) begin
          if (!rb_ben[i]) ref_mem[rb_addr][i*BW +: BW] = rb_data[i*BW +: BW];
        end
      end
      rb_valid = 1'b1; rb_addr = addr_q_model; rb_data = din; rb_ben = ben_q_model;
    end
    if (cur != K_IDLE) begin
      addr_q_model = a;
      ben_q_model  = b_n;
    end
    pend_valid = (cur == K_WRITE);
    pend_data  = wd;
    op_before  = op_now;
    rd_before  = rd_now;
    op_now     = cur;
    rd_now     = (cur == K_READ) ? model_read(a) : '0;
    #1;
  endtask

  logic [AW-1:0] addr_q_model;
  logic [NB-1:0] ben_q_model;

  task automatic wr(input logic [AW-1:0] a, input logic [NB-1:0] b,
                    input logic [DW-1:0] d, input string tag);
    step(1'b0, 1'b0, b, a, d, 1'b0, 1'b0, tag);
  endtask

  task automatic rd(input logic [AW-1:0] a, input string tag);
    step(1'b0, 1'b1, 2'b11, a, '0, 1'b0, 1'b0, tag);
  endtask

  task automatic ds(input string tag);
    step(1'b1, 1'b1, 2'b11, '0, '0, 1'b0, 1'b0, tag);
  endtask

  task automatic do_reset(input logic [1:0] m);
    rst_n = 1'b0; sel_n = 1'b1; wen_n = 1'b1; ben_n = '1; addr = '0;
    oe_n = 1'b0; sleep = 1'b0; din = '0; rmode = m;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    mode_now = m;
    rb_valid = 1'b0; pend_valid = 1'b0;
    op_now = K_IDLE; op_before = K_IDLE; rd_now = '0; rd_before = '0;
    addr_q_model = '0; ben_q_model = '1;
    // R13: idle output after reset
    chk("R13", "reset idle", dout_en, 1'b0, dout, '0);
  endtask

  task automatic directed(input string mtag);
    logic [DW-1:0] v;
    // R2 / R5: pending write visible before it is committed
    v = rnd_word();
    wr(4'd5, 2'b00, v, "R2");
    rd(4'd5, "R5");
    // R3: lane 0 only (bits 8:0)
    wr(4'd6, 2'b10, rnd_word(), "R3");
    rd(4'd6, "R5");
    // lane 1 only (bits 17:9), commits the lane-0 write
    wr(4'd7, 2'b01, rnd_word(), "R3");
    rd(4'd6, "R3");
    rd(4'd7, "R5");
    rd(4'd5, "R2");
    ds("R1");
    // R4: abort leaves the word intact, still commits the previous entry
    wr(4'd5, 2'b11, rnd_word(), "R4");
    rd(4'd5, "R4");
    rd(4'd7, "R4");
    // R1: deselect with write enable low does nothing
    step(1'b1, 1'b0, 2'b00, 4'd5, rnd_word(), 1'b0, 1'b0, "R1");
    ds("R1");
    rd(4'd5, "R1");
    // R9: read, write, read with no gap
    rd(4'd2, "R9");
    wr(4'd2, 2'b00, rnd_word(), "R9");
    rd(4'd2, "R9");
    rd(4'd3, "R9");
    ds(mtag);
    // R10: output enable high idles a read
    step(1'b0, 1'b1, 2'b11, 4'd2, '0, 1'b1, 1'b0, "R10");
    step(1'b0, 1'b1, 2'b11, 4'd3, '0, 1'b1, 1'b0, "R10");
    rd(4'd4, "R10");
    ds("R10");
    // R11: write whose data edge falls in sleep is lost
    wr(4'd9, 2'b00, rnd_word(), "R11");
    step(1'b1, 1'b1, 2'b11, '0, '0, 1'b0, 1'b1, "R11");
    rd(4'd9, "R11");
    step(1'b0, 1'b1, 2'b11, 4'd9, '0, 1'b0, 1'b1, "R11");
    ds("R11");
    wr(4'd10, 2'b00, rnd_word(), mtag);
    wr(4'd10, 2'b11, rnd_word(), mtag);
    rd(4'd10, mtag);
    ds(mtag);
  endtask

  task automatic random_run(input int n, input string mtag);
    for (int k = 0; k < n; k++) begin
      logic s_n, w_n, oe, slp;
      logic [NB-1:0] b;
      s_n = ($urandom_range(0, 9) == 0);
      w_n = ($urandom_range(0, 9) < 6);
      b   = NB'($urandom_range(0, 3));
      oe  = ($urandom_range(0, 19) == 0);
      slp = ($urandom_range(0, 29) == 0);
      step(s_n, w_n, b, AW'($urandom_range(0, DEPTH - 1)), rnd_word(), oe, slp, mtag);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    do_reset(2'b01);
    for (int a = 0; a < DEPTH; a++) wr(AW'(a), 2'b00, rnd_word(), "R2");
    wr('0, 2'b11, '0, "R4");
    ds("R1");
    directed("R6");
    random_run(300, "R6");
    // R13: pending write dropped by reset, array kept
    wr(4'd3, 2'b00, rnd_word(), "R13");
    ds("R13");
    do_reset(2'b00);
    rd(4'd3, "R13");
    directed("R7");
    random_run(300, "R7");
    do_reset(2'b10);
    directed("R8");
    random_run(300, "R8");
    do_reset(2'b11);
    directed("R12");
    random_run(200, "R12");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL R13 watchdog: actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule